// File: doc/BRIEF.md
# PWM Fault Shutdown Controller

This block turns four filtered fault levels into enables for two groups of PWM outputs. When a fault input shows a rising edge, the block latches an event flag for that input and turns off the output group the input guards. It does not wait for a PWM cycle boundary to do so. Software sees the flags and a shared interrupt request. It clears a flag by pulsing the matching acknowledge strobe, which stands for writing a one to an acknowledge bit.

Turning a group back on happens only at a PWM cycle-start strobe. Each fault input has its own mode select.

- **Manual mode.** The flag must already be clear when the cycle starts.
  - Faults 1 and 3 then release their group whatever their level is.
  - Faults 2 and 4 also need their filtered level to be low at that cycle start. If it is not, they try again at the next one.
- **Automatic mode.** This mode ignores the flag and releases at the first cycle start with the fault low.

A group stays off while any of its faults still holds it. Glitch filtering and waveform generation are done outside the block.

Top module: `pwm_fault_ctrl`

## Requirements
- R1: After reset, `flag_o` is all zero, `grp_en_o` is all one and `irq_o` is low.
- R2: A rising edge on `fault_lvl_i[i]` (bit i is fault i+1) sets `flag_o[i]` and clears the enable of that fault's group at the next clock edge. This happens in both modes and does not depend on `cyc_start_i`.
- R3: A one on `ack_wr_i[i]` clears `flag_o[i]` at the next clock edge. In manual mode (`manual_mode_i[i]`=1), a group held by fault i is not re-enabled at a cycle start while `flag_o[i]` is set. This includes an acknowledge given in the same clock as the cycle start.
- R4: In manual mode, faults 1 and 3 (bits 0 and 2) release their hold at the first cycle start after the flag is clear, even if the fault level is still high.
- R5: In manual mode, faults 2 and 4 (bits 1 and 3) release their hold only at a cycle start where the fault level is low. Otherwise they stay held until a later cycle start.
- R6: In automatic mode (`manual_mode_i[i]`=0), fault i releases its hold at the first cycle start with the fault level low, whether or not `flag_o[i]` is set.
- R7: Faults 1 and 3 guard group A (`grp_en_o[0]`) and faults 2 and 4 guard group B (`grp_en_o[1]`). A group is enabled only when none of its faults holds it.
- R8: If an acknowledge and a new rising edge on the same fault fall in the same clock, the flag stays set.
- R9: `irq_o` is the OR over all faults of `flag_o[i]` AND `irq_en_i[i]`. It drops in the same cycle that the enable is cleared, and at the edge that clears the flag.
- R10: A group enable goes from 0 to 1 only at the clock edge that samples `cyc_start_i` high.
- R11: A rising fault edge arriving in the same clock as a release condition for that fault keeps the group disabled and the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fault_lvl_i | input | 4 | Filtered fault levels, bit i is fault i+1 |
| cyc_start_i | input | 1 | One-clock strobe marking the start of a PWM cycle |
| manual_mode_i | input | 4 | Per-fault mode: 1 manual, 0 automatic |
| irq_en_i | input | 4 | Per-fault interrupt enables |
| ack_wr_i | input | 4 | Per-fault acknowledge strobes, a one clears that flag |
| grp_en_o | output | 2 | Output group enables, bit 0 group A, bit 1 group B |
| flag_o | output | 4 | Latched fault event flags |
| irq_o | output | 1 | Fault interrupt request |

## Verification
The hardest situations to reach are the same-clock collisions:
- an acknowledge landing on a cycle-start edge;
- a new rising edge landing on the very edge where the fault would otherwise be released.

Each scenario first holds a fault, then lowers it and acknowledges it. It then drives the two colliding inputs in the same low clock phase, so both are sampled by the same edge. The manual release of faults 1 and 3 while the fault is still high is reached by keeping the level up across the acknowledge and the following cycle-start strobe.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;

    // Per-fault channel state
    typedef struct packed {
        logic prev;   // fault level seen at the last edge
        logic flag;   // latched event flag
        logic hold;   // this fault keeps its group disabled
    } chan_st_t;

    localparam chan_st_t CHAN_RST = '{prev: 1'b0, flag: 1'b0, hold: 1'b0};

endpackage

// File: rtl/pwm_fault_chan.sv
module pwm_fault_chan
    import pwm_fault_pkg::*;
#(
    parameter bit LEVEL_CHECK = 1'b0  // manual release also needs a low level
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_i,
    input  logic cyc_start_i,
    input  logic manual_i,
    input  logic ack_i,
    output logic flag_o,
    output logic hold_o
);

    chan_st_t st_d, st_q;
    logic     rise_w;
    logic     rel_w;

    always_comb begin
        st_d      = st_q;
        rise_w    = fault_i & ~st_q.prev;
        st_d.prev = fault_i;

        // a new event wins over an acknowledge in the same clock
        st_d.flag = rise_w | (st_q.flag & ~ack_i);

        if (manual_i) begin
            if (LEVEL_CHECK) rel_w = cyc_start_i & ~st_q.flag & ~fault_i;
            else             rel_w = cyc_start_i & ~st_q.flag;
        end else begin
            rel_w = cyc_start_i & ~fault_i;
        end

        // a new event wins over a release in the same clock
        st_d.hold = rise_w | (st_q.hold & ~rel_w);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CHAN_RST;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign hold_o = st_q.hold;

endmodule

// File: rtl/pwm_fault_grp.sv
module pwm_fault_grp #(
    parameter int NUM_FAULTS = 4,
    parameter int NUM_GROUPS = 2
) (
    input  logic [NUM_FAULTS-1:0] hold_i,
    output logic [NUM_GROUPS-1:0] grp_en_o
);

    // fault i guards group (i mod NUM_GROUPS)
    always_comb begin
        grp_en_o = '1;
        for (int i = 0; i < NUM_FAULTS; i++) begin
            if (hold_i[i]) grp_en_o[i % NUM_GROUPS] = 1'b0;
        end
    end

endmodule

// File: rtl/pwm_fault_irq.sv
module pwm_fault_irq #(
    parameter int NUM_FAULTS = 4
) (
    input  logic [NUM_FAULTS-1:0] flag_i,
    input  logic [NUM_FAULTS-1:0] en_i,
    output logic                  irq_o
);

    assign irq_o = |(flag_i & en_i);

endmodule

// File: rtl/pwm_fault_ctrl.sv
module pwm_fault_ctrl #(
    parameter int                   NUM_FAULTS       = 4,
    parameter int                   NUM_GROUPS       = 2,
    parameter logic [NUM_FAULTS-1:0] LEVEL_CHECK_MASK = 4'b1010
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_FAULTS-1:0] fault_lvl_i,
    input  logic                  cyc_start_i,
    input  logic [NUM_FAULTS-1:0] manual_mode_i,
    input  logic [NUM_FAULTS-1:0] irq_en_i,
    input  logic [NUM_FAULTS-1:0] ack_wr_i,
    output logic [NUM_GROUPS-1:0] grp_en_o,
    output logic [NUM_FAULTS-1:0] flag_o,
    output logic                  irq_o
);

    logic [NUM_FAULTS-1:0] hold_w;

    for (genvar i = 0; i < NUM_FAULTS; i++) begin : g_chan
        pwm_fault_chan #(
            .LEVEL_CHECK (LEVEL_CHECK_MASK[i])
        ) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .fault_i     (fault_lvl_i[i]),
            .cyc_start_i (cyc_start_i),
            .manual_i    (manual_mode_i[i]),
            .ack_i       (ack_wr_i[i]),
            .flag_o      (flag_o[i]),
            .hold_o      (hold_w[i])
        );
    end

    pwm_fault_grp #(
        .NUM_FAULTS (NUM_FAULTS),
        .NUM_GROUPS (NUM_GROUPS)
    ) u_grp (
        .hold_i   (hold_w),
        .grp_en_o (grp_en_o)
    );

    pwm_fault_irq #(
        .NUM_FAULTS (NUM_FAULTS)
    ) u_irq (
        .flag_i (flag_o),
        .en_i   (irq_en_i),
        .irq_o  (irq_o)
    );

endmodule

// File: rtl/pwm_fault_ctrl_chk.sv
module pwm_fault_ctrl_chk #(
    parameter int                   NUM_FAULTS       = 4,
    parameter int                   NUM_GROUPS       = 2,
    parameter logic [NUM_FAULTS-1:0] LEVEL_CHECK_MASK = 4'b1010
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_FAULTS-1:0] fault_lvl_i,
    input logic                  cyc_start_i,
    input logic [NUM_FAULTS-1:0] manual_mode_i,
    input logic [NUM_FAULTS-1:0] irq_en_i,
    input logic [NUM_FAULTS-1:0] ack_wr_i,
    input logic [NUM_GROUPS-1:0] grp_en_o,
    input logic [NUM_FAULTS-1:0] flag_o,
    input logic                  irq_o
);

    // R9: no enabled flag means no request
    always_comb begin
        if (rst_n) begin
            assert_irq_quiet_R9: assert (((flag_o & irq_en_i) != '0) || !irq_o)
                else $error("irq_o high with no enabled flag");
        end
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        // R10: re-enable only on the edge sampling a cycle start
        assert_reenable_at_cycle_R10: assert property (
            @(posedge clk) disable iff (!rst_n)
            $rose(grp_en_o[g]) |-> $past(cyc_start_i))
            else $error("group %0d re-enabled without cycle start", g);
    end

    for (genvar i = 0; i < NUM_FAULTS; i++) begin : g_flt
        // R2: rising fault sets flag and disables its group
        assert_rise_disables_R2: assert property (
            @(posedge clk) disable iff (!rst_n)
            $rose(fault_lvl_i[i]) |=> (flag_o[i] && !grp_en_o[i % NUM_GROUPS]))
            else $error("fault %0d edge did not disable", i);

        // R3: acknowledge with fault low clears the flag
        assert_ack_clears_R3: assert property (
            @(posedge clk) disable iff (!rst_n)
            (ack_wr_i[i] && !fault_lvl_i[i]) |=> !flag_o[i])
            else $error("fault %0d flag not cleared by ack", i);

        // R3: manual mode never releases while the flag is set
        assert_manual_needs_ack_R3: assert property (
            @(posedge clk) disable iff (!rst_n)
            $rose(grp_en_o[i % NUM_GROUPS]) |-> !$past(flag_o[i] && manual_mode_i[i]))
            else $error("fault %0d released with flag set", i);

        // R5: level-checked faults release only with the level low
        if (LEVEL_CHECK_MASK[i]) begin : g_lvl
            assert_low_level_release_R5: assert property (
                @(posedge clk) disable iff (!rst_n)
                $rose(grp_en_o[i % NUM_GROUPS]) |-> !$past(fault_lvl_i[i]))
                else $error("fault %0d released with level high", i);
        end
    end

endmodule

bind pwm_fault_ctrl pwm_fault_ctrl_chk #(
    .NUM_FAULTS       (NUM_FAULTS),
    .NUM_GROUPS       (NUM_GROUPS),
    .LEVEL_CHECK_MASK (LEVEL_CHECK_MASK)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fault_lvl_i   (fault_lvl_i),
    .cyc_start_i   (cyc_start_i),
    .manual_mode_i (manual_mode_i),
    .irq_en_i      (irq_en_i),
    .ack_wr_i      (ack_wr_i),
    .grp_en_o      (grp_en_o),
    .flag_o        (flag_o),
    .irq_o         (irq_o)
);

// File: tb/tb_pwm_fault_ctrl.sv
module tb_pwm_fault_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] fault_lvl_i = '0;
    logic       cyc_start_i = 1'b0;
    logic [3:0] manual_mode_i = 4'b1111;
    logic [3:0] irq_en_i = 4'b1111;
    logic [3:0] ack_wr_i = '0;
    logic [1:0] grp_en_o;
    logic [3:0] flag_o;
    logic       irq_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;  // 250 MHz

    pwm_fault_ctrl dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .fault_lvl_i   (fault_lvl_i),
        .cyc_start_i   (cyc_start_i),
        .manual_mode_i (manual_mode_i),
        .irq_en_i      (irq_en_i),
        .ack_wr_i      (ack_wr_i),
        .grp_en_o      (grp_en_o),
        .flag_o        (flag_o),
        .irq_o         (irq_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // inputs change just after a falling edge; one call passes one rising edge
    task automatic step();
        @(negedge clk);
    endtask

    task automatic cyc_pulse();
        cyc_start_i = 1'b1;
        step();
        cyc_start_i = 1'b0;
    endtask

    task automatic ack(input logic [3:0] m);
        ack_wr_i = m;
        step();
        ack_wr_i = '0;
    endtask

    // return to the idle state: faults low, flags cleared, groups on
    task automatic clean();
        fault_lvl_i = '0;
        step();
        ack(4'hF);
        cyc_pulse();
    endtask

    task automatic t_reset();
        chk("R1", "flags after reset", {4'h0, flag_o}, 8'h00);
        chk("R1", "groups after reset", {6'h0, grp_en_o}, 8'h03);
        chk("R1", "irq after reset", {7'h0, irq_o}, 8'h00);
    endtask

    task automatic t_manual_free();
        manual_mode_i = 4'b1111;
        fault_lvl_i = 4'b0001;
        step();
        chk("R2", "fault1 flag", {4'h0, flag_o}, 8'h01);
        chk("R7", "fault1 disables group A only", {6'h0, grp_en_o}, 8'h02);
        chk("R9", "irq with flag and enable", {7'h0, irq_o}, 8'h01);
        cyc_pulse();
        chk("R3", "no release while flag set", {6'h0, grp_en_o}, 8'h02);
        ack(4'b0001);
        chk("R3", "ack clears flag", {4'h0, flag_o}, 8'h00);
        chk("R9", "irq drops with flag", {7'h0, irq_o}, 8'h00);
        chk("R10", "no release without cycle start", {6'h0, grp_en_o}, 8'h02);
        cyc_pulse();
        chk("R4", "fault1 releases while still high", {6'h0, grp_en_o}, 8'h03);
        clean();
    endtask

    task automatic t_manual_level();
        manual_mode_i = 4'b1111;
        fault_lvl_i = 4'b0010;
        step();
        chk("R7", "fault2 disables group B only", {6'h0, grp_en_o}, 8'h01);
        ack(4'b0010);
        cyc_pulse();
        chk("R5", "fault2 held while high at cycle start", {6'h0, grp_en_o}, 8'h01);
        fault_lvl_i = 4'b0000;
        step();
        chk("R10", "low level alone does not release", {6'h0, grp_en_o}, 8'h01);
        cyc_pulse();
        chk("R5", "fault2 releases at low cycle start", {6'h0, grp_en_o}, 8'h03);
        clean();
    endtask

    task automatic t_auto();
        manual_mode_i = 4'b0000;
        fault_lvl_i = 4'b0100;
        step();
        chk("R2", "auto fault3 disables group A", {6'h0, grp_en_o}, 8'h02);
        fault_lvl_i = 4'b0000;
        cyc_pulse();
        chk("R6", "auto releases with flag set", {6'h0, grp_en_o}, 8'h03);
        chk("R6", "auto flag still set", {4'h0, flag_o}, 8'h04);
        fault_lvl_i = 4'b1000;
        step();
        cyc_pulse();
        chk("R6", "auto fault4 held while high", {6'h0, grp_en_o}, 8'h01);
        fault_lvl_i = 4'b0000;
        cyc_pulse();
        chk("R6", "auto fault4 released when low", {6'h0, grp_en_o}, 8'h03);
        clean();
        manual_mode_i = 4'b1111;
    endtask

    task automatic t_group_share();
        fault_lvl_i = 4'b0101;
        step();
        fault_lvl_i = 4'b0000;
        ack(4'b0001);
        cyc_pulse();
        chk("R7", "group A held by fault3", {6'h0, grp_en_o}, 8'h02);
        ack(4'b0100);
        cyc_pulse();
        chk("R7", "group A released when both clear", {6'h0, grp_en_o}, 8'h03);
        clean();
    endtask

    task automatic t_races();
        // acknowledge on the cycle-start edge
        fault_lvl_i = 4'b0001;
        step();
        fault_lvl_i = 4'b0000;
        ack_wr_i = 4'b0001;
        cyc_start_i = 1'b1;
        step();
        ack_wr_i = '0;
        cyc_start_i = 1'b0;
        chk("R3", "ack at cycle start too late", {6'h0, grp_en_o}, 8'h02);
        cyc_pulse();
        chk("R4", "released at following cycle start", {6'h0, grp_en_o}, 8'h03);
        // acknowledge and new edge together
        fault_lvl_i = 4'b0001;
        step();
        fault_lvl_i = 4'b0000;
        step();
        fault_lvl_i = 4'b0001;
        ack_wr_i = 4'b0001;
        step();
        ack_wr_i = '0;
        chk("R8", "flag kept on ack with new edge", {4'h0, flag_o}, 8'h01);
        clean();
        // new edge on a release edge
        fault_lvl_i = 4'b0001;
        step();
        fault_lvl_i = 4'b0000;
        ack(4'b0001);
        fault_lvl_i = 4'b0001;
        cyc_start_i = 1'b1;
        step();
        cyc_start_i = 1'b0;
        chk("R11", "group stays off on edge at release", {6'h0, grp_en_o}, 8'h02);
        chk("R11", "flag set on edge at release", {4'h0, flag_o}, 8'h01);
        clean();
    endtask

    task automatic t_irq_enable();
        fault_lvl_i = 4'b1000;
        step();
        chk("R9", "irq on fault4", {7'h0, irq_o}, 8'h01);
        irq_en_i = 4'b0111;
        #1;
        chk("R9", "irq drops with enable", {7'h0, irq_o}, 8'h00);
        irq_en_i = 4'b1111;
        #1;
        chk("R9", "irq back with enable", {7'h0, irq_o}, 8'h01);
        clean();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all requirements actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        step();
        step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_manual_free();
        t_manual_level();
        t_auto();
        t_group_share();
        t_races();
        t_irq_enable();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule